// File: doc/BRIEF.md
# Three-Channel Programmable Interval Timer

This block holds three independent counting channels behind a small byte-wide register port. Each channel counts qualifying clock ticks (cycles where the shared tick enable and that channel's gate are both high) from the moment its count was last loaded. It drives its output purely from its counting mode and the number of ticks counted so far. The modes give a one-shot level, a single-tick rate pulse, a square wave and a single-tick strobe. A loaded count of zero means 65536.

Software picks a channel and a mode with a control byte. It then writes the 16-bit reload value as a low byte, a high byte, or a low byte followed by a high byte. The same port can freeze a channel's remaining count, or its status byte, for a later read. For each channel the block also flags whether the next counted tick will change that channel's output level, which lets a scheduler skip the ticks on which nothing happens.

Top module: `ivt_timer`

## Requirements
- R1: After reset each channel is in mode 3 with a reload value of 0 (an effective count of 65536), low-then-high byte access, BCD flag clear and zero ticks counted, so every output is high.
- R2: A channel's counted ticks advance only on cycles where `tick` and that channel's `gate` bit are both high. The counted ticks are the value the output and the remaining count are computed from.
- R3: In modes 0 and 1 the output is low while the counted ticks are below the effective count. It is high once they reach or pass it.
- R4: In mode 2 the output is high exactly when the counted ticks are a nonzero multiple of the effective count, and low otherwise.
- R5: In mode 3, with p = counted ticks modulo the effective count, the output is high while p < (count+1)/2 (rounded down) and low for the rest of each period.
- R6: In modes 4 and 5 the output is high only while the counted ticks equal the effective count.
- R7: Mode values 6 and 7 behave as mode 0 for the output.
- R8: A reload value of 0 counts as 65536: in mode 0 the output is still low after 65535 ticks and goes high on tick 65536.
- R9: The control byte is written at address 3. Bits [7:6] select channel 0 to 2, bits [5:4] select the access (01 low byte only, 10 high byte only, 11 low then high), bits [3:1] hold the mode and bit 0 holds the BCD flag. A control byte restarts the count from zero while keeping the reload value. A data write at address 0 to 2 loads the reload value and restarts the count: in low-only access the high byte is zero, in high-only access the low byte is zero, and in low-then-high access the first byte is only held and the load happens on the second byte.
- R10: A control byte with access bits 00 freezes the channel's remaining count into a latch, where the remaining count is (count − p) mod 65536. Reads then return the latched bytes until the last byte of the access sequence has been read. Further latch commands are ignored while a latch is pending.
- R11: A control byte with bits [7:6] = 11 latches the status byte of every channel whose bit is set in bits [2:0]. The status byte is {output, 0, access[1:0], mode[2:0], BCD}. The next data read of that channel returns it once; reads after that return count bytes.
- R12: `edge_soon[i]` is high exactly when one more counted tick would change `tout[i]`.
- R13: With no latch pending, data reads return bytes of the live remaining count, in the byte order set by the access field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count enable shared by all channels |
| gate | input | N_CH | Per-channel count qualifier |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (advances the read sequence) |
| addr | input | 2 | 0 to 2 channel data, 3 control |
| wdata | input | BW | Write byte |
| rdata | output | BW | Read byte for the addressed channel (combinational) |
| tout | output | N_CH | Channel outputs |
| edge_soon | output | N_CH | Next counted tick changes the channel output |

## Verification
The bench steps every mode through counts of 1, 2 and 3, and a few longer periods, against a model that works from the absolute tick count. A design that wrapped its period counter one tick late, or that rounded the square-wave half period up, would show a shifted output edge there. Count 1 is the sharpest case: mode 2 must stay high after the first tick and mode 3 must never fall. The count-of-zero case runs a full 65536 ticks, so a block that treated zero as zero or as 65535 would switch too early. Byte sequencing is probed with a half-written reload, which must not disturb the running count, with a second latch command that must not replace the first one, and with a status read that must come before the count bytes; a design that mishandled any of these returns the wrong byte at the port.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  typedef enum logic [1:0] {
    ACC_LATCH = 2'b00,
    ACC_LO    = 2'b01,
    ACC_HI    = 2'b10,
    ACC_PAIR  = 2'b11
  } acc_e;

  localparam logic [1:0] SEL_STATUS = 2'b11;
  localparam logic [1:0] ADDR_CTL   = 2'b11;
  localparam logic [2:0] RST_MODE   = 3'd3;
endpackage

// File: rtl/ivt_count_core.sv
module ivt_count_core #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv_en,
  input  logic          restart,
  input  logic [2:0]    mode,
  input  logic [CW-1:0] reload,
  output logic          out,
  output logic          edge_next,
  output logic [CW-1:0] remain
);
  localparam int EW = CW + 1;
  localparam logic [EW-1:0] FULL = EW'(1) << CW;

  logic [EW-1:0] el_q, el_d, el_inc, el_step, cnt, half;
  logic          run_q, run_d;
  logic [2:0]    m;
  logic          periodic;

  function automatic logic lvl(input logic [2:0] mm, input logic [EW-1:0] e,
                               input logic st, input logic [EW-1:0] c,
                               input logic [EW-1:0] h);
    case (mm)
      3'd2:       lvl = st && (e == '0);
      3'd3:       lvl = (e < h);
      3'd4, 3'd5: lvl = (e == c);
      default:    lvl = (e >= c);
    endcase
  endfunction

  always_comb begin
    m        = (mode > 3'd5) ? 3'd0 : mode;
    cnt      = (reload == '0) ? FULL : {1'b0, reload};
    half     = (cnt + EW'(1)) >> 1;
    periodic = (m == 3'd2) || (m == 3'd3);
    el_inc   = el_q + EW'(1);
    if (periodic) el_step = (el_inc == cnt) ? '0 : el_inc;
    else          el_step = (el_q > cnt) ? el_q : el_inc;

    el_d  = el_q;
    run_d = run_q;
    if (restart) begin
      el_d  = '0;
      run_d = 1'b0;
    end else if (adv_en) begin
      el_d  = el_step;
      run_d = 1'b1;
    end

    out       = lvl(m, el_q, run_q, cnt, half);
    edge_next = (lvl(m, el_step, 1'b1, cnt, half) != out);
    remain    = CW'(cnt - el_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      el_q  <= '0;
      run_q <= 1'b0;
    end else begin
      el_q  <= el_d;
      run_q <= run_d;
    end
  end
endmodule

// File: rtl/ivt_chan_regs.sv
module ivt_chan_regs import ivt_pkg::*; #(
  parameter int BW = 8,
  localparam int CW = 2 * BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_wr,
  input  logic [1:0]    ctl_acc,
  input  logic [2:0]    ctl_mode,
  input  logic          ctl_bcd,
  input  logic          cnt_lat,
  input  logic          st_lat,
  input  logic          dat_wr,
  input  logic          dat_rd,
  input  logic [BW-1:0] wdata,
  input  logic          out_lvl,
  input  logic [CW-1:0] remain,
  output logic [2:0]    mode,
  output logic [CW-1:0] reload,
  output logic          restart,
  output logic [BW-1:0] rdata
);
  acc_e          acc_q, acc_d;
  logic [2:0]    mode_q, mode_d;
  logic          bcd_q, bcd_d;
  logic [CW-1:0] reload_q, reload_d, lat_q, lat_d, src;
  logic [BW-1:0] hold_q, hold_d, stat_q, stat_d, stat_now, pick;
  logic          wseq_q, wseq_d, rseq_q, rseq_d;
  logic          clat_q, clat_d, slat_q, slat_d;
  logic          hi_sel, last;

  always_comb begin
    stat_now = BW'({out_lvl, 1'b0, acc_q, mode_q, bcd_q});
    src      = clat_q ? lat_q : remain;
    hi_sel   = (acc_q == ACC_HI) || ((acc_q == ACC_PAIR) && rseq_q);
    last     = (acc_q != ACC_PAIR) || rseq_q;
    pick     = hi_sel ? src[CW-1:BW] : src[BW-1:0];
    rdata    = slat_q ? stat_q : pick;

    acc_d = acc_q;  mode_d = mode_q;  bcd_d = bcd_q;  reload_d = reload_q;
    hold_d = hold_q;  stat_d = stat_q;  lat_d = lat_q;
    wseq_d = wseq_q;  rseq_d = rseq_q;  clat_d = clat_q;  slat_d = slat_q;
    restart = 1'b0;

    if (ctl_wr) begin
      acc_d   = acc_e'(ctl_acc);
      mode_d  = ctl_mode;
      bcd_d   = ctl_bcd;
      wseq_d  = 1'b0;
      rseq_d  = 1'b0;
      clat_d  = 1'b0;
      restart = 1'b1;
    end else if (cnt_lat) begin
      if (!clat_q) begin
        lat_d  = remain;
        clat_d = 1'b1;
        rseq_d = 1'b0;
      end
    end else if (st_lat) begin
      if (!slat_q) begin
        stat_d = stat_now;
        slat_d = 1'b1;
      end
    end else if (dat_wr) begin
      case (acc_q)
        ACC_LO: begin
          reload_d = {{BW{1'b0}}, wdata};
          restart  = 1'b1;
        end
        ACC_HI: begin
          reload_d = {wdata, {BW{1'b0}}};
          restart  = 1'b1;
        end
        ACC_PAIR: begin
          if (!wseq_q) begin
            hold_d = wdata;
            wseq_d = 1'b1;
          end else begin
            reload_d = {wdata, hold_q};
            wseq_d   = 1'b0;
            restart  = 1'b1;
          end
        end
        default: ;
      endcase
    end else if (dat_rd) begin
      if (slat_q) begin
        slat_d = 1'b0;
      end else begin
        if (acc_q == ACC_PAIR) rseq_d = !rseq_q;
        if (last) clat_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q    <= ACC_PAIR;
      mode_q   <= RST_MODE;
      bcd_q    <= 1'b0;
      reload_q <= '0;
      hold_q   <= '0;
      stat_q   <= '0;
      lat_q    <= '0;
      wseq_q   <= 1'b0;
      rseq_q   <= 1'b0;
      clat_q   <= 1'b0;
      slat_q   <= 1'b0;
    end else begin
      acc_q    <= acc_d;
      mode_q   <= mode_d;
      bcd_q    <= bcd_d;
      reload_q <= reload_d;
      hold_q   <= hold_d;
      stat_q   <= stat_d;
      lat_q    <= lat_d;
      wseq_q   <= wseq_d;
      rseq_q   <= rseq_d;
      clat_q   <= clat_d;
      slat_q   <= slat_d;
    end
  end

  assign mode   = mode_q;
  assign reload = reload_q;
endmodule

// File: rtl/ivt_timer.sv
module ivt_timer import ivt_pkg::*; #(
  parameter int N_CH = 3,
  parameter int BW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic [N_CH-1:0] gate,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [1:0]      addr,
  input  logic [BW-1:0]   wdata,
  output logic [BW-1:0]   rdata,
  output logic [N_CH-1:0] tout,
  output logic [N_CH-1:0] edge_soon
);
  localparam int CW = 2 * BW;

  logic       ctl_hit;
  logic [1:0] sel;
  acc_e       wacc;
  logic [BW-1:0] rd_bus [N_CH];

  assign ctl_hit = wr_en && (addr == ADDR_CTL);
  assign sel     = wdata[7:6];
  assign wacc    = acc_e'(wdata[5:4]);

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    logic          ctl_wr_i, cnt_lat_i, st_lat_i, dat_wr_i, dat_rd_i;
    logic          restart_i, out_i, edge_i;
    logic [2:0]    mode_i;
    logic [CW-1:0] reload_i, remain_i;
    logic [BW-1:0] rd_i;

    assign ctl_wr_i  = ctl_hit && (sel == 2'(i)) && (wacc != ACC_LATCH);
    assign cnt_lat_i = ctl_hit && (sel == 2'(i)) && (wacc == ACC_LATCH);
    assign st_lat_i  = ctl_hit && (sel == SEL_STATUS) && wdata[i];
    assign dat_wr_i  = wr_en && (addr == 2'(i));
    assign dat_rd_i  = rd_en && (addr == 2'(i));

    ivt_chan_regs #(.BW(BW)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctl_wr   (ctl_wr_i),
      .ctl_acc  (wdata[5:4]),
      .ctl_mode (wdata[3:1]),
      .ctl_bcd  (wdata[0]),
      .cnt_lat  (cnt_lat_i),
      .st_lat   (st_lat_i),
      .dat_wr   (dat_wr_i),
      .dat_rd   (dat_rd_i),
      .wdata    (wdata),
      .out_lvl  (out_i),
      .remain   (remain_i),
      .mode     (mode_i),
      .reload   (reload_i),
      .restart  (restart_i),
      .rdata    (rd_i)
    );

    ivt_count_core #(.CW(CW)) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .adv_en    (tick && gate[i]),
      .restart   (restart_i),
      .mode      (mode_i),
      .reload    (reload_i),
      .out       (out_i),
      .edge_next (edge_i),
      .remain    (remain_i)
    );

    assign rd_bus[i]    = rd_i;
    assign tout[i]      = out_i;
    assign edge_soon[i] = edge_i;
  end

  always_comb begin
    rdata = '0;
    for (int k = 0; k < N_CH; k++) begin
      if (addr == 2'(k)) rdata = rd_bus[k];
    end
  end
endmodule

// File: rtl/ivt_timer_chk.sv
module ivt_timer_chk #(
  parameter int N_CH = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            tick,
  input logic            wr_en,
  input logic [N_CH-1:0] gate,
  input logic [N_CH-1:0] tout,
  input logic [N_CH-1:0] edge_soon
);
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_en) |=> $stable(tout));

  p_gate_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate[0] && !wr_en) |=> $stable(tout[0]));

  p_edge_pred_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && gate[0] && !wr_en) |=> ((tout[0] != $past(tout[0])) == $past(edge_soon[0])));

  p_edge_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_soon[0] && !wr_en) |=> $stable(tout[0]));

  p_out_known_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown({tout, edge_soon}));
endmodule

bind ivt_timer ivt_timer_chk #(.N_CH(N_CH)) u_chk (.*);

// File: tb/ivt_timer_test.sv
module ivt_timer_test;
  logic       clk = 1'b0;
  logic       rst_n, tick, wr_en, rd_en;
  logic [2:0] gate;
  logic [1:0] addr;
  logic [7:0] wdata, rdata, rb;
  logic [2:0] tout, edge_soon;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  ivt_timer uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .gate(gate), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .tout(tout), .edge_soon(edge_soon)
  );

  // {mode[2:0], count[15:0], ticks[7:0]}
  localparam int NV = 14;
  localparam logic [26:0] VEC [NV] = '{
    {3'd0, 16'd3, 8'd6}, {3'd1, 16'd1, 8'd4}, {3'd2, 16'd1, 8'd4},
    {3'd2, 16'd3, 8'd10}, {3'd2, 16'd2, 8'd7}, {3'd3, 16'd3, 8'd10},
    {3'd3, 16'd2, 8'd6}, {3'd3, 16'd1, 8'd4}, {3'd3, 16'd5, 8'd12},
    {3'd4, 16'd3, 8'd6}, {3'd5, 16'd1, 8'd4}, {3'd4, 16'd2, 8'd5},
    {3'd6, 16'd2, 8'd5}, {3'd7, 16'd3, 8'd6}
  };

  function automatic logic ref_out(input int m, input int c, input int d);
    int mm;
    mm = (m > 5) ? 0 : m;
    case (mm)
      2:       return (d != 0) && (d % c == 0);
      3:       return (d % c) < ((c + 1) / 2);
      4, 5:    return d == c;
      default: return d >= c;
    endcase
  endfunction

  function automatic string req_of(input int m);
    case (m)
      0, 1:    return "R3";
      2:       return "R4";
      3:       return "R5";
      4, 5:    return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  initial begin
    repeat (150000) @(negedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int m, c, nt;
    logic [15:0] c16;
    rst_n = 1'b0; tick = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    gate = 3'b111; addr = 2'd0; wdata = 8'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 outputs", tout, 3'b111);
    chk("R1 edge", edge_soon, 3'b000);
    bus_wr(2'd3, 8'hC7);                       // R11 status latch all channels
    bus_rd(2'd0, rb); chk("R11 R1 status ch0", rb, 8'hB6);
    bus_rd(2'd1, rb); chk("R11 R1 status ch1", rb, 8'hB6);
    bus_rd(2'd2, rb); chk("R11 R1 status ch2", rb, 8'hB6);
    bus_rd(2'd0, rb); chk("R13 R1 live lo", rb, 8'h00);
    bus_rd(2'd0, rb); chk("R13 R1 live hi", rb, 8'h00);

    // vector table on channel 0
    for (int v = 0; v < NV; v++) begin
      m   = int'(VEC[v][26:24]);
      c16 = VEC[v][23:8];
      nt  = int'(VEC[v][7:0]);
      c   = (c16 == 16'd0) ? 65536 : int'(c16);
      bus_wr(2'd3, {2'b00, 2'b11, VEC[v][26:24], 1'b0});
      bus_wr(2'd0, c16[7:0]);
      bus_wr(2'd0, c16[15:8]);
      for (int d = 0; d <= nt; d++) begin
        chk(req_of(m), tout[0], ref_out(m, c, d));
        chk("R12 edge", edge_soon[0], ref_out(m, c, d + 1) != ref_out(m, c, d));
        if (d < nt) ticks(1);
      end
    end

    // R8 count zero means 65536
    bus_wr(2'd3, 8'h30);
    bus_wr(2'd0, 8'h00);
    bus_wr(2'd0, 8'h00);
    ticks(65535);
    chk("R8 low at 65535", tout[0], 1'b0);
    chk("R12 R8 edge at 65535", edge_soon[0], 1'b1);
    bus_wr(2'd3, 8'h00);
    bus_rd(2'd0, rb); chk("R8 R10 remain lo", rb, 8'h01);
    bus_rd(2'd0, rb); chk("R8 R10 remain hi", rb, 8'h00);
    ticks(1);
    chk("R8 high at 65536", tout[0], 1'b1);

    // R2 gate and R10 latch on channel 1
    bus_wr(2'd3, 8'h70);
    bus_wr(2'd1, 8'd100);
    bus_wr(2'd1, 8'd0);
    gate[1] = 1'b0;
    ticks(10);
    bus_wr(2'd3, 8'h40);
    bus_rd(2'd1, rb); chk("R2 gated lo", rb, 8'd100);
    bus_rd(2'd1, rb); chk("R2 gated hi", rb, 8'd0);
    gate[1] = 1'b1;
    ticks(10);
    bus_wr(2'd3, 8'h40);
    ticks(5);
    bus_wr(2'd3, 8'h40);                       // ignored while pending
    bus_rd(2'd1, rb); chk("R10 frozen lo", rb, 8'd90);
    bus_rd(2'd1, rb); chk("R10 frozen hi", rb, 8'd0);
    bus_rd(2'd1, rb); chk("R13 live lo", rb, 8'd85);
    bus_rd(2'd1, rb); chk("R13 live hi", rb, 8'd0);

    // R9 low-only access
    bus_wr(2'd3, 8'h50);
    bus_wr(2'd1, 8'd7);
    ticks(6);
    chk("R9 lo-only before count", tout[1], 1'b0);
    ticks(1);
    chk("R9 lo-only at count", tout[1], 1'b1);

    // R9 high-only access on channel 2
    bus_wr(2'd3, 8'hA0);
    bus_wr(2'd2, 8'h01);
    bus_rd(2'd2, rb); chk("R9 hi-only 256", rb, 8'h01);
    ticks(1);
    bus_rd(2'd2, rb); chk("R9 hi-only 255", rb, 8'h00);

    // R9 half-written pair leaves count running
    bus_wr(2'd3, 8'h30);
    bus_wr(2'd0, 8'd10);
    bus_wr(2'd0, 8'd0);
    ticks(3);
    bus_wr(2'd0, 8'd50);
    bus_wr(2'd3, 8'h00);
    bus_rd(2'd0, rb); chk("R9 held byte lo", rb, 8'd7);
    bus_rd(2'd0, rb); chk("R9 held byte hi", rb, 8'd0);
    bus_wr(2'd0, 8'd0);
    bus_wr(2'd3, 8'h00);
    bus_rd(2'd0, rb); chk("R9 pair load lo", rb, 8'd50);
    bus_rd(2'd0, rb); chk("R9 pair load hi", rb, 8'd0);
    ticks(4);
    bus_wr(2'd3, 8'h30);
    bus_wr(2'd3, 8'h00);
    bus_rd(2'd0, rb); chk("R9 control restart lo", rb, 8'd50);
    bus_rd(2'd0, rb); chk("R9 control restart hi", rb, 8'd0);

    // R11 status format with mode 5 and BCD
    bus_wr(2'd3, 8'hBB);
    bus_wr(2'd3, 8'hC4);
    bus_rd(2'd2, rb); chk("R11 status ch2", rb, 8'h3B);
    bus_rd(2'd2, rb); chk("R11 R13 after status lo", rb, 8'h00);
    bus_rd(2'd2, rb); chk("R11 R13 after status hi", rb, 8'h01);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule